// File: doc/BRIEF.md
# Out-of-Order Primitive Issue Scheduler

This block sits between the fetch stage of a rasteriser and a small pool of independent rasterisation engines. Decoded primitives arrive in program order, each with one destination bounding box, zero to two source bounding boxes and an opaque payload handle. Each accepted primitive gets a destination slot, and the slot's index becomes the primitive's tag. The primitive also gets a candidate buffer and one source slot per source region. Its source slots are stamped with the same tag.

A separate overlap-check block compares the incoming boxes against the boxes this unit publishes. It hands the unit a dependence vector with one bit per destination slot. A candidate issues once every bit of its vector has cleared. When more than one candidate is ready, a pseudo-random rotating start picks among them. An engine reports completion by returning the tag. That tag releases the destination slot and every source slot carrying it, and clears the matching bit in every waiting candidate.

Top module: `prim_issue_unit`

## Requirements
- R1: `inReady` is high exactly when the current state has a free destination slot, a free candidate buffer, and at least as many free source slots as the primitive needs. `inNumSrc` of 0, 1 or 2 needs that many source slots, and 3 counts as two. A primitive is taken on a cycle with `inValid` and `inReady` both high.
- R2: An accepted primitive takes the lowest-numbered free destination slot as its tag. One cycle later, that bit of `destValid` is set and the slot's field of `destBoxes` holds `inDstBox`. Its source slots become valid on the same cycle, carrying that tag in `srcTags`.
- R3: The stored dependence vector is `inDepVec` ANDed with the destination slots that are valid in the accepting cycle and are not being completed in that cycle.
- R4: `issueValid` is high in a cycle exactly when some candidate is valid with an all-zero dependence vector and at least one `engFree` bit is high. `issueEng` is then one-hot on the lowest-numbered free engine.
- R5: `issueTag` and `issuePayload` belong to the issued candidate. Its buffer is released on the clock edge, so the same tag never issues twice.
- R6: Among several ready candidates, the choice starts from a position taken from an 8-bit LFSR and rotates over the buffers. The candidate picked is always ready, and it is not always the lowest-tagged ready one.
- R7: A completion (`doneValid[e]` with tag `doneTag[e]`) clears that `destValid` bit and every source slot holding the tag one cycle later. It also clears that bit in all candidates, so a candidate whose last dependence completes can issue in the following cycle.
- R8: Each engine may report a completion in the same cycle, and all of them take effect together.
- R9: After reset no slot or buffer is valid, `issueValid` is low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Primitive offered by fetch |
| inReady | output | 1 | Room for the offered primitive |
| inNumSrc | input | 2 | Number of source regions (3 treated as 2) |
| inDstBox | input | 4*CW | Destination bounding box |
| inSrcBox0 | input | 4*CW | First source bounding box |
| inSrcBox1 | input | 4*CW | Second source bounding box |
| inPayload | input | PW | Opaque payload handle |
| inDepVec | input | NUM_DEST | Dependence bits from the overlap checker |
| engFree | input | NUM_ENG | Engine can take a primitive this cycle |
| issueValid | output | 1 | A primitive is issued this cycle |
| issueEng | output | NUM_ENG | One-hot target engine |
| issueTag | output | TW | Tag of the issued primitive |
| issuePayload | output | PW | Payload of the issued primitive |
| doneValid | input | NUM_ENG | Per-engine completion strobe |
| doneTag | input | NUM_ENG*TW | Per-engine completed tag |
| destValid | output | NUM_DEST | Destination slot occupancy |
| destBoxes | output | NUM_DEST*4*CW | Destination boxes, slot k at bits k*4*CW |
| srcValid | output | NUM_SRC | Source slot occupancy |
| srcBoxes | output | NUM_SRC*4*CW | Source boxes per slot |
| srcTags | output | NUM_SRC*TW | Owning tag per source slot |

## Verification
`inReady` and the issue outputs are combinational on registered state, so they are due in the same cycle as the state they reflect. They are sampled one nanosecond after the falling edge, once the inputs for that cycle have settled. Acceptance, issue release and completion clears all land on the next rising edge. The occupancy vectors, boxes, tags and the readiness this unlocks are therefore compared one cycle after the stimulus, against a model that is advanced at that same edge. The issue choice is random, so the model checks that the pick is legal and adopts the tag the design chose.

// File: rtl/piu_pkg.sv
package piu_pkg;
  // Slot indices travel in a fixed-width field; parameters stay below 256.
  typedef logic [7:0] idx_t;

  typedef struct packed {
    logic accept;
    idx_t dstIdx;
    idx_t candIdx;
    logic src0En;
    idx_t src0Idx;
    logic src1En;
    idx_t src1Idx;
    logic issue;
    idx_t issueCand;
    idx_t issueEng;
  } strobe_t;
endpackage

// File: rtl/piu_ctrl.sv
module piu_ctrl
  import piu_pkg::*;
#(
  parameter int NUM_CAND = 4,
  parameter int NUM_DEST = 6,
  parameter int NUM_SRC  = 6,
  parameter int NUM_ENG  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [1:0]          inNumSrc,
  input  logic [NUM_DEST-1:0] destValid,
  input  logic [NUM_SRC-1:0]  srcValid,
  input  logic [NUM_CAND-1:0] candValid,
  input  logic [NUM_CAND-1:0] candReady,
  input  logic [NUM_ENG-1:0]  engFree,
  output logic                inReady,
  output strobe_t             stb
);
  localparam int SCW = $clog2(NUM_SRC + 1);

  logic [7:0]     lfsrQ;
  logic           dstFree, candFree, anyReady, anyEng, srcOk;
  logic [SCW-1:0] srcCnt;
  logic [1:0]     needSrc;
  idx_t           dstIdx, candIdx, s0Idx, s1Idx, pickIdx, engIdx;

  // Pseudo-random start position for the ready search.
  always_ff @(posedge clk) begin
    if (!rstN) lfsrQ <= 8'hA5;
    else       lfsrQ <= {lfsrQ[6:0], lfsrQ[7] ^ lfsrQ[5] ^ lfsrQ[4] ^ lfsrQ[3]};
  end

  always_comb begin
    dstFree = 1'b0; dstIdx = '0;
    for (int k = NUM_DEST - 1; k >= 0; k--)
      if (!destValid[k]) begin dstFree = 1'b1; dstIdx = idx_t'(k); end

    candFree = 1'b0; candIdx = '0;
    for (int c = NUM_CAND - 1; c >= 0; c--)
      if (!candValid[c]) begin candFree = 1'b1; candIdx = idx_t'(c); end

    srcCnt = '0; s0Idx = '0; s1Idx = '0;
    for (int j = 0; j < NUM_SRC; j++)
      if (!srcValid[j]) begin
        if (srcCnt == SCW'(0))      s0Idx = idx_t'(j);
        else if (srcCnt == SCW'(1)) s1Idx = idx_t'(j);
        srcCnt = srcCnt + SCW'(1);
      end

    needSrc = (inNumSrc == 2'd3) ? 2'd2 : inNumSrc;
    srcOk   = srcCnt >= SCW'(needSrc);
    inReady = dstFree && candFree && srcOk;

    anyReady = 1'b0; pickIdx = '0;
    for (int off = NUM_CAND - 1; off >= 0; off--) begin
      int pos;
      pos = (int'(lfsrQ) + off) % NUM_CAND;
      if (candReady[pos]) begin anyReady = 1'b1; pickIdx = idx_t'(pos); end
    end

    anyEng = 1'b0; engIdx = '0;
    for (int e = NUM_ENG - 1; e >= 0; e--)
      if (engFree[e]) begin anyEng = 1'b1; engIdx = idx_t'(e); end

    stb           = '0;
    stb.accept    = inValid && inReady;
    stb.dstIdx    = dstIdx;
    stb.candIdx   = candIdx;
    stb.src0En    = stb.accept && (needSrc != 2'd0);
    stb.src0Idx   = s0Idx;
    stb.src1En    = stb.accept && (needSrc == 2'd2);
    stb.src1Idx   = s1Idx;
    stb.issue     = anyReady && anyEng;
    stb.issueCand = pickIdx;
    stb.issueEng  = engIdx;
  end

  AST_SRC_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    stb.src1En |-> (stb.src0Idx != stb.src1Idx) && !srcValid[0 +: 1] || srcValid[0 +: 1] || (stb.src0Idx != stb.src1Idx)); // R2
endmodule

// File: rtl/piu_data.sv
module piu_data
  import piu_pkg::*;
#(
  parameter int NUM_CAND = 4,
  parameter int NUM_DEST = 6,
  parameter int NUM_SRC  = 6,
  parameter int NUM_ENG  = 2,
  parameter int CW       = 8,
  parameter int PW       = 16,
  localparam int TW      = $clog2(NUM_DEST),
  localparam int BW      = 4 * CW
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [BW-1:0]           inDstBox,
  input  logic [BW-1:0]           inSrcBox0,
  input  logic [BW-1:0]           inSrcBox1,
  input  logic [PW-1:0]           inPayload,
  input  logic [NUM_DEST-1:0]     inDepVec,
  input  logic [NUM_ENG-1:0]      doneValid,
  input  logic [NUM_ENG*TW-1:0]   doneTag,
  output logic [NUM_DEST-1:0]     destValid,
  output logic [NUM_SRC-1:0]      srcValid,
  output logic [NUM_CAND-1:0]     candValid,
  output logic [NUM_CAND-1:0]     candReady,
  output logic [NUM_DEST*BW-1:0]  destBoxes,
  output logic [NUM_SRC*BW-1:0]   srcBoxes,
  output logic [NUM_SRC*TW-1:0]   srcTags,
  output logic [TW-1:0]           issueTag,
  output logic [PW-1:0]           issuePayload
);
  logic [NUM_DEST-1:0] destValidQ;
  logic [BW-1:0]       destBoxQ [NUM_DEST];
  logic [NUM_SRC-1:0]  srcValidQ;
  logic [BW-1:0]       srcBoxQ  [NUM_SRC];
  logic [TW-1:0]       srcTagQ  [NUM_SRC];
  logic [NUM_CAND-1:0] candValidQ;
  logic [NUM_DEST-1:0] candDepQ [NUM_CAND];
  logic [TW-1:0]       candTagQ [NUM_CAND];
  logic [PW-1:0]       candPayQ [NUM_CAND];
  logic [NUM_DEST-1:0] doneMask;
  logic [TW-1:0]       newTag;
  wire  [7:0]          unusedEng = stb.issueEng;

  assign newTag = stb.dstIdx[TW-1:0];

  // Decode every engine's returned tag into one clear mask.
  always_comb begin
    doneMask = '0;
    for (int e = 0; e < NUM_ENG; e++)
      for (int k = 0; k < NUM_DEST; k++)
        if (doneValid[e] && doneTag[e*TW +: TW] == TW'(k)) doneMask[k] = 1'b1;
  end

  for (genvar k = 0; k < NUM_DEST; k++) begin : g_dest
    always_ff @(posedge clk) begin
      if (!rstN) destValidQ[k] <= 1'b0;
      else if (stb.accept && stb.dstIdx == idx_t'(k)) begin
        destValidQ[k] <= 1'b1;
        destBoxQ[k]   <= inDstBox;
      end else if (doneMask[k]) destValidQ[k] <= 1'b0;
    end
    assign destBoxes[k*BW +: BW] = destBoxQ[k];

    AST_DEST_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
      (stb.accept && stb.dstIdx == idx_t'(k)) |=> destValidQ[k]); // R2
    AST_DEST_FREED: assert property (@(posedge clk) disable iff (!rstN)
      (doneMask[k] && !(stb.accept && stb.dstIdx == idx_t'(k))) |=> !destValidQ[k]); // R7
  end

  for (genvar j = 0; j < NUM_SRC; j++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN) srcValidQ[j] <= 1'b0;
      else if (stb.src0En && stb.src0Idx == idx_t'(j)) begin
        srcValidQ[j] <= 1'b1; srcBoxQ[j] <= inSrcBox0; srcTagQ[j] <= newTag;
      end else if (stb.src1En && stb.src1Idx == idx_t'(j)) begin
        srcValidQ[j] <= 1'b1; srcBoxQ[j] <= inSrcBox1; srcTagQ[j] <= newTag;
      end else if (srcValidQ[j] && doneMask[srcTagQ[j]]) srcValidQ[j] <= 1'b0;
    end
    assign srcBoxes[j*BW +: BW] = srcBoxQ[j];
    assign srcTags[j*TW +: TW]  = srcTagQ[j];
  end

  for (genvar c = 0; c < NUM_CAND; c++) begin : g_cand
    always_ff @(posedge clk) begin
      if (!rstN) begin
        candValidQ[c] <= 1'b0;
        candDepQ[c]   <= '0;
      end else if (stb.accept && stb.candIdx == idx_t'(c)) begin
        candValidQ[c] <= 1'b1;
        candDepQ[c]   <= inDepVec & destValidQ & ~doneMask;
        candTagQ[c]   <= newTag;
        candPayQ[c]   <= inPayload;
      end else begin
        if (stb.issue && stb.issueCand == idx_t'(c)) candValidQ[c] <= 1'b0;
        candDepQ[c] <= candDepQ[c] & ~doneMask;
      end
    end
    assign candReady[c] = candValidQ[c] && (candDepQ[c] == '0);

    AST_ISSUE_READY: assert property (@(posedge clk) disable iff (!rstN)
      (stb.issue && stb.issueCand == idx_t'(c)) |-> candReady[c]); // R4
    AST_ISSUE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
      (stb.issue && stb.issueCand == idx_t'(c)) |=> !candValidQ[c]); // R5
    AST_DEP_MASKED: assert property (@(posedge clk) disable iff (!rstN)
      (stb.accept && stb.candIdx == idx_t'(c)) |=> (candDepQ[c] & ~$past(destValidQ)) == '0); // R3
  end

  always_comb begin
    issueTag = '0; issuePayload = '0;
    for (int c = 0; c < NUM_CAND; c++)
      if (stb.issueCand == idx_t'(c)) begin
        issueTag = candTagQ[c]; issuePayload = candPayQ[c];
      end
  end

  assign destValid = destValidQ;
  assign srcValid  = srcValidQ;
  assign candValid = candValidQ;
endmodule

// File: rtl/prim_issue_unit.sv
module prim_issue_unit
  import piu_pkg::*;
#(
  parameter int NUM_CAND = 4,
  parameter int NUM_ENG  = 2,
  parameter int NUM_SRC  = 6,
  parameter int CW       = 8,
  parameter int PW       = 16,
  localparam int NUM_DEST = NUM_CAND + NUM_ENG,
  localparam int TW       = $clog2(NUM_DEST),
  localparam int BW       = 4 * CW
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [1:0]             inNumSrc,
  input  logic [BW-1:0]          inDstBox,
  input  logic [BW-1:0]          inSrcBox0,
  input  logic [BW-1:0]          inSrcBox1,
  input  logic [PW-1:0]          inPayload,
  input  logic [NUM_DEST-1:0]    inDepVec,
  input  logic [NUM_ENG-1:0]     engFree,
  output logic                   issueValid,
  output logic [NUM_ENG-1:0]     issueEng,
  output logic [TW-1:0]          issueTag,
  output logic [PW-1:0]          issuePayload,
  input  logic [NUM_ENG-1:0]     doneValid,
  input  logic [NUM_ENG*TW-1:0]  doneTag,
  output logic [NUM_DEST-1:0]    destValid,
  output logic [NUM_DEST*BW-1:0] destBoxes,
  output logic [NUM_SRC-1:0]     srcValid,
  output logic [NUM_SRC*BW-1:0]  srcBoxes,
  output logic [NUM_SRC*TW-1:0]  srcTags
);
  strobe_t             stb;
  logic [NUM_CAND-1:0] candValid, candReady;

  piu_ctrl #(.NUM_CAND(NUM_CAND), .NUM_DEST(NUM_DEST), .NUM_SRC(NUM_SRC),
             .NUM_ENG(NUM_ENG)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inNumSrc(inNumSrc),
    .destValid(destValid), .srcValid(srcValid), .candValid(candValid),
    .candReady(candReady), .engFree(engFree), .inReady(inReady), .stb(stb));

  piu_data #(.NUM_CAND(NUM_CAND), .NUM_DEST(NUM_DEST), .NUM_SRC(NUM_SRC),
             .NUM_ENG(NUM_ENG), .CW(CW), .PW(PW)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .inDstBox(inDstBox),
    .inSrcBox0(inSrcBox0), .inSrcBox1(inSrcBox1), .inPayload(inPayload),
    .inDepVec(inDepVec), .doneValid(doneValid), .doneTag(doneTag),
    .destValid(destValid), .srcValid(srcValid), .candValid(candValid),
    .candReady(candReady), .destBoxes(destBoxes), .srcBoxes(srcBoxes),
    .srcTags(srcTags), .issueTag(issueTag), .issuePayload(issuePayload));

  assign issueValid = stb.issue;
  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    assign issueEng[e] = stb.issue && stb.issueEng == idx_t'(e);
  end

  AST_ISSUE_TO_FREE: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (issueEng & engFree) != '0); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !(&destValid) && !(&candValid)); // R1
endmodule

// File: tb/tb_prim_issue_unit.sv
`timescale 1ns/1ps
module tb_prim_issue_unit;
  localparam int NC = 4, NE = 2, ND = 6, NS = 6, CW = 8, PW = 16, TW = 3, BW = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, inReady;
  logic [1:0] inNumSrc = '0;
  logic [BW-1:0] inDstBox = '0, inSrcBox0 = '0, inSrcBox1 = '0;
  logic [PW-1:0] inPayload = '0;
  logic [ND-1:0] inDepVec = '0;
  logic [NE-1:0] engFree = '0;
  logic issueValid;
  logic [NE-1:0] issueEng;
  logic [TW-1:0] issueTag;
  logic [PW-1:0] issuePayload;
  logic [NE-1:0] doneValid = '0;
  logic [NE*TW-1:0] doneTag = '0;
  logic [ND-1:0] destValid;
  logic [ND*BW-1:0] destBoxes;
  logic [NS-1:0] srcValid;
  logic [NS*BW-1:0] srcBoxes;
  logic [NS*TW-1:0] srcTags;

  prim_issue_unit #(.NUM_CAND(NC), .NUM_ENG(NE), .NUM_SRC(NS), .CW(CW), .PW(PW)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inNumSrc(inNumSrc),
    .inDstBox(inDstBox), .inSrcBox0(inSrcBox0), .inSrcBox1(inSrcBox1),
    .inPayload(inPayload), .inDepVec(inDepVec), .engFree(engFree),
    .issueValid(issueValid), .issueEng(issueEng), .issueTag(issueTag),
    .issuePayload(issuePayload), .doneValid(doneValid), .doneTag(doneTag),
    .destValid(destValid), .destBoxes(destBoxes), .srcValid(srcValid),
    .srcBoxes(srcBoxes), .srcTags(srcTags));

  always #4 clk = ~clk;

  int vecs = 0, errs = 0;

  // Reference state, indexed by tag.
  bit mDv[ND]; int mSc[ND]; bit mPend[ND];
  logic [ND-1:0] mDep[ND]; logic [PW-1:0] mPay[ND]; logic [BW-1:0] mBox[ND];
  int srcFree = NS;
  bit eBusy[NE]; int eLeft[NE]; int eTag[NE];
  bit engHold = 0;
  int pIn = 0, depPct = 0, srcMode = -1, maxLat = 6;
  int boxTag = -1; logic [BW-1:0] boxExp;
  int stallSeen = 0, spreadSeen = 0, dualDone = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic stateChecks();
    logic [ND-1:0] dv;
    int cnt[ND];
    for (int k = 0; k < ND; k++) begin dv[k] = mDv[k]; cnt[k] = 0; end
    chk(destValid == dv, "R2/R7", "destValid", destValid, dv);
    chk($countones(srcValid) == NS - srcFree, "R2/R7", "source slots in use",
        $countones(srcValid), NS - srcFree);
    for (int j = 0; j < NS; j++)
      if (srcValid[j]) cnt[srcTags[j*TW +: TW]]++;
    for (int k = 0; k < ND; k++)
      chk(cnt[k] == mSc[k], "R7", $sformatf("source slots of tag %0d", k), cnt[k], mSc[k]);
    if (boxTag >= 0) begin
      chk(destBoxes[boxTag*BW +: BW] == boxExp, "R2", "destination box", destBoxes[boxTag*BW +: BW], boxExp);
      boxTag = -1;
    end
  endtask

  task automatic cycle();
    int nS, freeD, lowD, nCand, nReady, minReady, lowE, acc, issT, issE;
    logic [ND-1:0] doneMask, oldDv;
    bit expReady, anyEng, expIssue;
    @(negedge clk);
    doneValid = '0;
    for (int e = 0; e < NE; e++) begin
      if (eBusy[e]) begin
        eLeft[e]--;
        if (eLeft[e] == 0) begin doneValid[e] = 1'b1; doneTag[e*TW +: TW] = TW'(eTag[e]); end
      end
      engFree[e] = !eBusy[e] && !engHold;
    end
    inValid   = $urandom_range(99) < pIn;
    inNumSrc  = (srcMode < 0) ? 2'($urandom_range(3)) : 2'(srcMode);
    inDstBox  = $urandom; inSrcBox0 = $urandom; inSrcBox1 = $urandom;
    inPayload = 16'($urandom);
    for (int k = 0; k < ND; k++) inDepVec[k] = $urandom_range(99) < depPct;
    #1;
    stateChecks();
    nS = (inNumSrc == 2'd3) ? 2 : int'(inNumSrc);
    freeD = 0; lowD = -1; nCand = 0; nReady = 0; minReady = -1;
    for (int k = ND - 1; k >= 0; k--) begin
      if (!mDv[k]) begin freeD++; lowD = k; end
      if (mPend[k]) nCand++;
    end
    for (int k = 0; k < ND; k++)
      if (mPend[k] && mDep[k] == '0) begin nReady++; if (minReady < 0) minReady = k; end
    expReady = freeD > 0 && nCand < NC && srcFree >= nS;
    chk(inReady == expReady, "R1", "inReady", inReady, expReady);
    if (engHold && !inReady) stallSeen++;
    anyEng = 1'b0; lowE = -1;
    for (int e = NE - 1; e >= 0; e--) if (engFree[e]) begin anyEng = 1'b1; lowE = e; end
    expIssue = nReady > 0 && anyEng;
    chk(issueValid == expIssue, "R4", "issueValid", issueValid, expIssue);
    issT = -1; issE = -1;
    if (issueValid) begin
      chk(lowE >= 0 && issueEng == NE'(1 << lowE), "R4", "issueEng", issueEng, lowE >= 0 ? (1 << lowE) : 0);
      issT = int'(issueTag);
      chk(mPend[issT] && mDep[issT] == '0, "R6", "issued tag is ready", issT, minReady);
      chk(issuePayload == mPay[issT], "R5", "issuePayload", issuePayload, mPay[issT]);
      if (nReady >= 2 && issT != minReady) spreadSeen++;
      for (int e = 0; e < NE; e++) if (issueEng[e]) issE = e;
    end
    acc = (inValid && inReady) ? lowD : -1;
    @(posedge clk);
    doneMask = '0;
    for (int k = 0; k < ND; k++) oldDv[k] = mDv[k];
    if (doneValid == '1) dualDone++;
    for (int e = 0; e < NE; e++)
      if (doneValid[e]) begin
        doneMask[eTag[e]] = 1'b1;
        mDv[eTag[e]] = 0; srcFree += mSc[eTag[e]]; mSc[eTag[e]] = 0; eBusy[e] = 0;
      end
    for (int k = 0; k < ND; k++) mDep[k] &= ~doneMask;
    if (acc >= 0) begin
      mDv[acc] = 1; mSc[acc] = nS; srcFree -= nS; mPend[acc] = 1;
      mDep[acc] = inDepVec & oldDv & ~doneMask;
      mPay[acc] = inPayload; mBox[acc] = inDstBox;
      boxTag = acc; boxExp = inDstBox;
    end
    if (issT >= 0) begin
      mPend[issT] = 0;
      if (issE >= 0) begin eBusy[issE] = 1; eLeft[issE] = $urandom_range(maxLat, 1); eTag[issE] = issT; end
    end
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    for (int k = 0; k < ND; k++) begin mDv[k] = 0; mSc[k] = 0; mPend[k] = 0; mDep[k] = '0; end
    for (int e = 0; e < NE; e++) begin eBusy[e] = 0; eLeft[e] = 0; eTag[e] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R9: reset state
    chk(inReady == 1'b1, "R9", "inReady after reset", inReady, 1);
    chk(issueValid == 1'b0, "R9", "issueValid after reset", issueValid, 0);
    chk(destValid == '0, "R9", "destValid after reset", destValid, 0);
    chk(srcValid == '0, "R9", "srcValid after reset", srcValid, 0);

    // R1: engines held, two sources each, fill until the unit stalls
    engHold = 1; pIn = 100; srcMode = 2; depPct = 0;
    repeat (12) cycle();
    chk(stallSeen > 0, "R1", "stall on full unit seen", stallSeen, 1);
    engHold = 0; srcMode = -1;

    // R3/R7: moderate dependences, random source counts
    depPct = 30; pIn = 70;
    repeat (1500) cycle();
    // R6/R8: independent primitives, short latency
    depPct = 0; maxLat = 1; pIn = 100;
    repeat (600) cycle();
    // R3: dense dependence chains
    depPct = 80; maxLat = 8; pIn = 60;
    repeat (800) cycle();
    // drain
    pIn = 0;
    repeat (300) cycle();
    chk(destValid == '0, "R7", "all slots released after drain", destValid, 0);
    chk(spreadSeen > 0, "R6", "pick other than lowest ready tag seen", spreadSeen, 1);
    chk(dualDone > 0, "R8", "simultaneous completions seen", dualDone, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule